// File: doc/BRIEF.md
# Transfer Register Bank with Two-Wire Slave and Update Lockout

This block holds a small bank of byte-wide transfer registers that an acquisition engine fills with decoded data. A microcontroller reads the bank over a two-wire I2C bus at any time. The same bus writes a mode byte that picks the acquisition engine's operating mode (line decoding or teletext packet decoding). A strap input picks one of two device addresses, so two parts can share a bus.

While the bus addresses the block, the bank is frozen. Store requests from the acquisition side are dropped, not held for later. This means a read always returns one consistent snapshot. A finished read refills every transfer register with FFh and releases the active-low data-available flag. A later store is then easy to spot. Stores that carry date/time content update the bank without pulling data-available low, so the host finds them only by polling.

Top module: `xfr_bank_i2c`

## Requirements
- R1: The 7-bit device address is {6'b001000, sel_i}. With sel_i low the block answers bus bytes 20h (write) and 21h (read). With sel_i high it answers 22h (write) and 23h (read). A matching address byte is acknowledged by pulling SDA low in the ninth clock.
- R2: In a write transfer, every data byte after the address is acknowledged and loaded into mode_o. The last byte wins. mode_o resets to 00h.
- R3: In a read transfer, bytes are sent MSB first starting at register 0. The index advances by one after each byte the master acknowledges and wraps from NUM_REGS-1 to 0. A master NACK stops the sending.
- R4: When the bus is idle, a cycle with st_we_i high writes st_data_i into register st_idx_i.
- R5: From the cycle that matches an address until the next STOP, store requests are dropped. They are not applied later.
- R6: Every transfer register resets to FFh. When a read transfer ends, by STOP or by a repeated START, all transfer registers become FFh.
- R7: dav_n_o resets high. An accepted store with st_dav_i high drives it low. An accepted store with st_dav_i low leaves it unchanged. The end of a read transfer drives it high.
- R8: An address byte that does not match is not acknowledged. It does not start the lockout, so stores made during that access are applied.
- R9: The end of a write transfer leaves both the transfer registers and dav_n_o unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line (asynchronous) |
| sda_i | input | 1 | Bus data line as seen on the wire (asynchronous) |
| sel_i | input | 1 | Address strap: selects 20h/21h (low) or 22h/23h (high) |
| sda_oe_o | output | 1 | Pull SDA low when 1 (open-drain enable) |
| st_we_i | input | 1 | Store request from acquisition logic |
| st_idx_i | input | IDX_W | Register index of the store |
| st_data_i | input | 8 | Byte to store |
| st_dav_i | input | 1 | Store signals data-available (0 for date/time content) |
| dav_n_o | output | 1 | Data available, active low |
| mode_o | output | 8 | Mode byte written over the bus |

## Verification
The bench targets the lockout window. It stores a known byte, opens a write access, stores a different byte in the middle of it, and then reads back. A design that queued the blocked store, or latched it, returns the second byte instead of the first.

Reads longer than the bank check the index wrap. A design that saturates or overruns the index returns the wrong register after the last one.

A repeated START that follows a one-byte read must refill the bank. A design that waits for STOP returns stale data in the second read.

The bench also checks three behaviours that a design could easily merge:
- A non-matching address must not freeze stores. A design that locks on any START loses the store made during that access.
- A store of date/time content must update the bank but leave dav_n_o high. A design that ties data-available to every store drives dav_n_o low.
- A write transfer must not refill the bank. A design that refills on any STOP wipes data the host has not yet read.

// File: rtl/xfr_pkg.sv
package xfr_pkg;
   localparam int BYTE_W = 8;
   localparam logic [BYTE_W-1:0] FILL_BYTE = 8'hFF;

   typedef enum logic [2:0] {
      BS_IDLE,
      BS_ADDR,
      BS_AACK,
      BS_WDAT,
      BS_WACK,
      BS_RDAT,
      BS_RACK
   } bus_st_t;
endpackage

// File: rtl/xfr_line_filt.sv
module xfr_line_filt #(
   parameter int   FILT_LEN = 3,
   parameter logic RST_VAL  = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_i,
   output logic line_o
);
   logic s1, s2;

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         s1 <= RST_VAL;
         s2 <= RST_VAL;
      end else begin
         s1 <= line_i;
         s2 <= s1;
      end

   generate
      if (FILT_LEN <= 1) begin : g_pass
         assign line_o = s2;
      end else begin : g_vote
         localparam int CW = $clog2(FILT_LEN + 1);
         logic          flt;
         logic [CW-1:0] run;

         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) begin
               flt <= RST_VAL;
               run <= '0;
            end else if (s2 == flt) begin
               run <= '0;
            end else if (run == CW'(FILT_LEN - 1)) begin
               flt <= s2;
               run <= '0;
            end else begin
               run <= run + 1'b1;
            end

         assign line_o = flt;
      end
   endgenerate
endmodule

// File: rtl/xfr_bus_slave.sv
module xfr_bus_slave
   import xfr_pkg::*;
#(
   parameter int          NUM_REGS = 16,
   parameter int          IDX_W    = 4,
   parameter logic [5:0]  DEV_BASE = 6'h08
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl,
   input  logic              sda,
   input  logic              sel,
   input  logic [BYTE_W-1:0] rd_data,
   output logic [IDX_W-1:0]  rd_idx,
   output logic              wr_stb,
   output logic [BYTE_W-1:0] wr_byte,
   output logic              busy,
   output logic              rd_end,
   output logic              sda_oe
);
   bus_st_t           st;
   logic              scl_q, sda_q;
   logic [3:0]        cnt;
   logic [BYTE_W-1:0] sh, tx;
   logic [IDX_W-1:0]  ptr, ptr_inc;
   logic              rw, rd_act, mack;
   logic              scl_r, scl_f, start_ev, stop_ev;

   assign scl_r    =  scl & ~scl_q;
   assign scl_f    = ~scl &  scl_q;
   assign start_ev =  scl &  scl_q &  sda_q & ~sda;
   assign stop_ev  =  scl &  scl_q & ~sda_q &  sda;
   assign rd_end   = (start_ev | stop_ev) & rd_act;
   assign ptr_inc  = (ptr == IDX_W'(NUM_REGS - 1)) ? '0 : ptr + 1'b1;
   assign rd_idx   = (st == BS_RACK) ? ptr_inc : ptr;

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         scl_q   <= 1'b1;
         sda_q   <= 1'b1;
         st      <= BS_IDLE;
         cnt     <= '0;
         sh      <= '0;
         tx      <= FILL_BYTE;
         ptr     <= '0;
         rw      <= 1'b0;
         rd_act  <= 1'b0;
         mack    <= 1'b0;
         busy    <= 1'b0;
         sda_oe  <= 1'b0;
         wr_stb  <= 1'b0;
         wr_byte <= '0;
      end else begin
         scl_q  <= scl;
         sda_q  <= sda;
         wr_stb <= 1'b0;
         if (stop_ev) begin
            st     <= BS_IDLE;
            sda_oe <= 1'b0;
            busy   <= 1'b0;
            rd_act <= 1'b0;
         end else if (start_ev) begin
            st     <= BS_ADDR;
            cnt    <= '0;
            sda_oe <= 1'b0;
            rd_act <= 1'b0;
         end else begin
            case (st)
               BS_ADDR: begin
                  if (scl_r) begin
                     sh  <= {sh[BYTE_W-2:0], sda};
                     cnt <= cnt + 1'b1;
                  end else if (scl_f && cnt == 4'd8) begin
                     cnt <= '0;
                     if (sh[7:1] == {DEV_BASE, sel}) begin
                        st     <= BS_AACK;
                        sda_oe <= 1'b1;
                        busy   <= 1'b1;
                        rw     <= sh[0];
                        ptr    <= '0;
                     end else begin
                        st <= BS_IDLE;
                     end
                  end
               end
               BS_AACK: begin
                  if (scl_f) begin
                     cnt <= '0;
                     if (rw) begin
                        st     <= BS_RDAT;
                        tx     <= rd_data;
                        sda_oe <= ~rd_data[7];
                        rd_act <= 1'b1;
                     end else begin
                        st     <= BS_WDAT;
                        sda_oe <= 1'b0;
                     end
                  end
               end
               BS_WDAT: begin
                  if (scl_r) begin
                     sh  <= {sh[BYTE_W-2:0], sda};
                     cnt <= cnt + 1'b1;
                  end else if (scl_f && cnt == 4'd8) begin
                     cnt     <= '0;
                     wr_stb  <= 1'b1;
                     wr_byte <= sh;
                     sda_oe  <= 1'b1;
                     st      <= BS_WACK;
                  end
               end
               BS_WACK: begin
                  if (scl_f) begin
                     st     <= BS_WDAT;
                     sda_oe <= 1'b0;
                     cnt    <= '0;
                  end
               end
               BS_RDAT: begin
                  if (scl_f) begin
                     if (cnt == 4'd7) begin
                        sda_oe <= 1'b0;
                        st     <= BS_RACK;
                     end else begin
                        tx     <= {tx[BYTE_W-2:0], 1'b1};
                        sda_oe <= ~tx[6];
                        cnt    <= cnt + 1'b1;
                     end
                  end
               end
               BS_RACK: begin
                  if (scl_r) begin
                     mack <= ~sda;
                  end else if (scl_f) begin
                     if (mack) begin
                        ptr    <= ptr_inc;
                        tx     <= rd_data;
                        sda_oe <= ~rd_data[7];
                        cnt    <= '0;
                        st     <= BS_RDAT;
                     end else begin
                        st <= BS_IDLE;
                     end
                  end
               end
               default: st <= BS_IDLE;
            endcase
         end
      end
endmodule

// File: rtl/xfr_regfile.sv
module xfr_regfile
   import xfr_pkg::*;
#(
   parameter int                NUM_REGS = 16,
   parameter int                IDX_W    = 4,
   parameter logic [BYTE_W-1:0] MODE_RST = 8'h00
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            st_we,
   input  logic [IDX_W-1:0]                st_idx,
   input  logic [BYTE_W-1:0]               st_data,
   input  logic                            st_dav,
   input  logic                            lock,
   input  logic                            fill,
   input  logic [IDX_W-1:0]                rd_idx,
   input  logic                            wr_stb,
   input  logic [BYTE_W-1:0]               wr_byte,
   output logic [BYTE_W-1:0]               rd_data,
   output logic [NUM_REGS-1:0][BYTE_W-1:0] bank,
   output logic                            dav_n,
   output logic [BYTE_W-1:0]               mode
);
   logic accept;

   assign accept  = st_we & ~lock & (32'(st_idx) < NUM_REGS);
   assign rd_data = bank[rd_idx];

   for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
      logic [BYTE_W-1:0] q;
      always_ff @(posedge clk or negedge rst_n)
         if (!rst_n)
            q <= FILL_BYTE;
         else if (fill)
            q <= FILL_BYTE;
         else if (accept && st_idx == IDX_W'(g))
            q <= st_data;
      assign bank[g] = q;
   end

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)
         dav_n <= 1'b1;
      else if (fill)
         dav_n <= 1'b1;
      else if (accept && st_dav)
         dav_n <= 1'b0;

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)
         mode <= MODE_RST;
      else if (wr_stb)
         mode <= wr_byte;
endmodule

// File: rtl/xfr_bank_i2c.sv
module xfr_bank_i2c
   import xfr_pkg::*;
#(
   parameter int                NUM_REGS = 16,
   parameter int                FILT_LEN = 3,
   parameter logic [5:0]        DEV_BASE = 6'h08,
   parameter logic [BYTE_W-1:0] MODE_RST = 8'h00,
   localparam int               IDX_W    = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   input  logic              sel_i,
   output logic              sda_oe_o,
   input  logic              st_we_i,
   input  logic [IDX_W-1:0]  st_idx_i,
   input  logic [7:0]        st_data_i,
   input  logic              st_dav_i,
   output logic              dav_n_o,
   output logic [7:0]        mode_o
);
   if (NUM_REGS < 2 || NUM_REGS > 256) begin : g_bad_regs
      $error("xfr_bank_i2c: NUM_REGS must lie in 2..256");
   end
   if (FILT_LEN < 1) begin : g_bad_filt
      $error("xfr_bank_i2c: FILT_LEN must be at least 1");
   end

   logic [1:0]                      raw_lines, clean_lines;
   logic [IDX_W-1:0]                rd_idx;
   logic [BYTE_W-1:0]               rd_data, wr_byte;
   logic                            wr_stb, bus_busy, rd_end;
   logic [NUM_REGS-1:0][BYTE_W-1:0] bank_q;

   assign raw_lines = {sda_i, scl_i};

   for (genvar l = 0; l < 2; l++) begin : g_line
      xfr_line_filt #(.FILT_LEN(FILT_LEN), .RST_VAL(1'b1)) u_filt (
         .clk    (clk),
         .rst_n  (rst_n),
         .line_i (raw_lines[l]),
         .line_o (clean_lines[l])
      );
   end

   xfr_bus_slave #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W), .DEV_BASE(DEV_BASE)) u_bus (
      .clk     (clk),
      .rst_n   (rst_n),
      .scl     (clean_lines[0]),
      .sda     (clean_lines[1]),
      .sel     (sel_i),
      .rd_data (rd_data),
      .rd_idx  (rd_idx),
      .wr_stb  (wr_stb),
      .wr_byte (wr_byte),
      .busy    (bus_busy),
      .rd_end  (rd_end),
      .sda_oe  (sda_oe_o)
   );

   xfr_regfile #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W), .MODE_RST(MODE_RST)) u_rf (
      .clk     (clk),
      .rst_n   (rst_n),
      .st_we   (st_we_i),
      .st_idx  (st_idx_i),
      .st_data (st_data_i),
      .st_dav  (st_dav_i),
      .lock    (bus_busy),
      .fill    (rd_end),
      .rd_idx  (rd_idx),
      .wr_stb  (wr_stb),
      .wr_byte (wr_byte),
      .rd_data (rd_data),
      .bank    (bank_q),
      .dav_n   (dav_n_o),
      .mode    (mode_o)
   );
endmodule

// File: rtl/xfr_bank_chk.sv
module xfr_bank_chk #(
   parameter int NUM_REGS = 16
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  st_we,
   input logic                  st_dav,
   input logic                  busy,
   input logic                  rd_end,
   input logic                  sda_oe,
   input logic                  dav_n,
   input logic [7:0]            mode,
   input logic [NUM_REGS*8-1:0] bank
);
   AST_DAV_FALL_FROM_STORE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(dav_n) |-> $past(st_we && st_dav && !busy)); // R7
   AST_DAV_RISE_AT_READ_END: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dav_n) |-> $past(rd_end)); // R7
   AST_FILL_ON_READ_END: assert property (@(posedge clk) disable iff (!rst_n)
      rd_end |=> (bank == '1)); // R6
   AST_NO_UPDATE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !rd_end) |=> $stable(bank)); // R5
   AST_DRIVE_ONLY_ADDRESSED: assert property (@(posedge clk) disable iff (!rst_n)
      sda_oe |-> busy); // R8
   AST_MODE_FROM_BUS: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(mode) |-> $past(busy)); // R2
endmodule

bind xfr_bank_i2c xfr_bank_chk #(.NUM_REGS(NUM_REGS)) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .st_we  (st_we_i),
   .st_dav (st_dav_i),
   .busy   (bus_busy),
   .rd_end (rd_end),
   .sda_oe (sda_oe_o),
   .dav_n  (dav_n_o),
   .mode   (mode_o),
   .bank   (bank_q)
);

// File: tb/xfr_bank_i2c_bench.sv
module xfr_bank_i2c_bench;
   localparam int NUM = 16;
   localparam int Q   = 16;
   localparam logic [5:0] BASE = 6'h08;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl_m = 1'b1, sda_m = 1'b1, sel = 1'b0;
   logic st_we = 1'b0, st_dav = 1'b0;
   logic [3:0] st_idx = '0;
   logic [7:0] st_data = '0;
   logic sda_oe, dav_n;
   logic [7:0] mode;
   wire  sda_line = sda_m & ~sda_oe;

   int checks = 0, failures = 0;
   logic done = 1'b0;
   logic [7:0] exp_bank [NUM];
   logic exp_dav_n;

   always #4 clk = ~clk;

   xfr_bank_i2c u_xfr_bank_i2c (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sel_i(sel),
      .sda_oe_o(sda_oe), .st_we_i(st_we), .st_idx_i(st_idx), .st_data_i(st_data),
      .st_dav_i(st_dav), .dav_n_o(dav_n), .mode_o(mode)
   );

   function automatic logic [7:0] addr_byte(input logic s, input logic rd);
      return {BASE, s, rd};
   endfunction

   function automatic logic [7:0] exp_at(input int i);
      return exp_bank[i % NUM];
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic qwait();
      repeat (Q) @(negedge clk);
   endtask

   task automatic bus_start();
      sda_m = 1'b1; qwait(); scl_m = 1'b1; qwait();
      sda_m = 1'b0; qwait(); scl_m = 1'b0; qwait();
   endtask

   task automatic bus_stop();
      sda_m = 1'b0; qwait(); scl_m = 1'b1; qwait(); sda_m = 1'b1; qwait();
   endtask

   task automatic bit_xfer(input logic b, output logic r);
      sda_m = b; qwait(); scl_m = 1'b1; qwait();
      r = sda_line; qwait(); scl_m = 1'b0; qwait();
   endtask

   task automatic send_byte(input logic [7:0] v, output logic acked);
      logic r;
      for (int i = 7; i >= 0; i--) bit_xfer(v[i], r);
      bit_xfer(1'b1, r);
      acked = ~r;
   endtask

   task automatic recv_byte(input logic give_ack, output logic [7:0] v);
      logic r;
      for (int i = 7; i >= 0; i--) begin
         bit_xfer(1'b1, r);
         v[i] = r;
      end
      bit_xfer(~give_ack, r);
      sda_m = 1'b1;
   endtask

   task automatic store(input int idx, input logic [7:0] d, input logic dv, input logic accept);
      @(negedge clk);
      st_we = 1'b1; st_idx = 4'(idx); st_data = d; st_dav = dv;
      @(negedge clk);
      st_we = 1'b0; st_dav = 1'b0;
      if (accept) begin
         exp_bank[idx] = d;
         if (dv) exp_dav_n = 1'b0;
      end
   endtask

   task automatic fill_model();
      for (int i = 0; i < NUM; i++) exp_bank[i] = 8'hFF;
      exp_dav_n = 1'b1;
   endtask

   task automatic do_read(input int len, input string req);
      logic ackd;
      logic [7:0] b;
      bus_start();
      send_byte(addr_byte(sel, 1'b1), ackd);
      chk("R1 read address ack", 32'(ackd), 1);
      for (int i = 0; i < len; i++) begin
         recv_byte(i != len - 1, b);
         chk(req, 32'(b), 32'(exp_at(i)));
      end
      bus_stop();
      fill_model();
      chk("R7 dav_n high after read", 32'(dav_n), 1);
   endtask

   initial begin
      logic ackd;
      logic [7:0] b;
      int sd;
      sd = $urandom(32'h5EED);
      fill_model();
      repeat (10) @(negedge clk);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);

      // reset state
      chk("R7 dav_n reset", 32'(dav_n), 1);
      chk("R2 mode reset", 32'(mode), 0);
      chk("R8 sda released at reset", 32'(sda_oe), 0);
      do_read(NUM, "R6 reset bank FF");

      // idle stores then wrap-around read
      for (int i = 0; i < NUM; i++) store(i, 8'($urandom), 1'b1, 1'b1);
      repeat (2) @(negedge clk);
      chk("R7 dav_n low after store", 32'(dav_n), 0);
      do_read(NUM + 2, "R3 R4 read with wrap");
      do_read(3, "R6 bank FF after read");

      // write transfer with lockout
      store(3, 8'h11, 1'b1, 1'b1);
      store(0, 8'h22, 1'b0, 1'b1);
      bus_start();
      send_byte(addr_byte(1'b0, 1'b0), ackd);
      chk("R1 write address 20h ack", 32'(ackd), 1);
      store(3, 8'h5A, 1'b1, 1'b0);
      send_byte(8'hC3, ackd);
      chk("R2 data byte ack", 32'(ackd), 1);
      store(5, 8'h66, 1'b1, 1'b0);
      send_byte(8'h3C, ackd);
      chk("R2 second data ack", 32'(ackd), 1);
      bus_stop();
      chk("R2 mode last byte", 32'(mode), 32'h3C);
      chk("R9 dav_n kept after write", 32'(dav_n), 0);
      do_read(6, "R5 R9 lockout and no fill on write");

      // mismatched address: no ack, no lockout
      bus_start();
      send_byte(addr_byte(1'b1, 1'b0), ackd);
      chk("R8 mismatched address nack", 32'(ackd), 0);
      store(1, 8'h77, 1'b1, 1'b1);
      bus_stop();
      chk("R8 dav_n low from store", 32'(dav_n), 0);
      do_read(2, "R8 store applied during foreign access");

      // strap high
      sel = 1'b1;
      bus_start();
      send_byte(addr_byte(1'b0, 1'b0), ackd);
      chk("R1 20h ignored when strap high", 32'(ackd), 0);
      bus_stop();
      bus_start();
      send_byte(addr_byte(1'b1, 1'b0), ackd);
      chk("R1 22h ack when strap high", 32'(ackd), 1);
      send_byte(8'h81, ackd);
      bus_stop();
      chk("R2 mode via 22h", 32'(mode), 32'h81);
      store(4, 8'hE4, 1'b1, 1'b1);
      do_read(5, "R1 read via 23h");
      sel = 1'b0;

      // date/time style store: no data-available
      store(2, 8'h99, 1'b0, 1'b1);
      repeat (2) @(negedge clk);
      chk("R7 dav_n unchanged by st_dav=0", 32'(dav_n), 1);
      do_read(3, "R4 R7 silent store readable");

      // repeated START ends a read
      store(0, 8'hAB, 1'b1, 1'b1);
      bus_start();
      send_byte(addr_byte(1'b0, 1'b1), ackd);
      recv_byte(1'b0, b);
      chk("R3 first byte register 0", 32'(b), 32'hAB);
      bus_start();
      fill_model();
      send_byte(addr_byte(1'b0, 1'b1), ackd);
      chk("R1 readdress ack", 32'(ackd), 1);
      recv_byte(1'b1, b);
      chk("R6 FF after repeated start", 32'(b), 32'hFF);
      recv_byte(1'b0, b);
      chk("R6 FF second byte", 32'(b), 32'hFF);
      bus_stop();
      chk("R7 dav_n high after repeated start", 32'(dav_n), 1);

      // constrained random rounds
      for (int r = 0; r < 5; r++) begin
         int n;
         n = 1 + int'($urandom % 8);
         for (int k = 0; k < n; k++)
            store(int'($urandom % NUM), 8'($urandom), 1'($urandom), 1'b1);
         repeat (2) @(negedge clk);
         chk("R7 random dav_n", 32'(dav_n), 32'(exp_dav_n));
         do_read(1 + int'($urandom % 20), "R3 R4 random read");
      end

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule